// File: doc/BRIEF.md
# Posted Write Buffer with Back-Off

This block sits between a local 32-bit write bus, styled after a classic microprocessor bus, and the master engine of a PCI-style interface. Memory write cycles from the local side are accepted with no wait states and stored in a small queue. Each entry holds one data word and its lane enables. The drain side sees a request whenever anything is waiting. It removes entries one at a time with a take strobe.

A local cycle opens with an active-low address strobe. Data phases follow on the next clocks, and an active-low burst-last marks the final word. When the store has no room, the block pulls an active-low back-off output low. The writer then holds its current word until an entry is freed. If a pop happens on the same clock as a push into a full store, the push goes through with no back-off.

One configuration bit selects the storage. When the bit is set, the four-entry queue is used. When the bit is clear, a single holding register is used, and each further write is backed off until the drain side has taken the held word. A change of the bit takes effect only once both stores are empty.

Top module: `pwbuf_top`

## Requirements
- R1: While reset is high and on the first clock after it, `lb_boff_n` is 1 and `wq_req` is 0.
- R2: Entries leave in the order they were accepted, and each one keeps all 36 bits unchanged. `wq_data` carries the data word and `wq_be_n` carries the active-low lane enables, bit k of which qualifies data bits 8k+7..8k.
- R3: A burst is accepted at one word per clock with `lb_boff_n` held at 1 for as long as free space remains.
- R4: With the queue selected and four entries stored, a data phase without a take on the same clock sees `lb_boff_n` at 0 and its word is not stored. The same word is accepted on the first clock on which space exists.
- R5: On a data phase in which the store is full and `wq_take` removes an entry, the word is accepted and `lb_boff_n` stays 1.
- R6: `wq_req` is 1 exactly when at least one entry is stored. The head entry stays on `wq_data`/`wq_be_n` until it is taken.
- R7: A write cycle opens when `lb_ads_n` is 0 with `lb_wr` and `lb_mem` both 1. Its data phases begin on the next clock, and it closes after the accepted word that carries `lb_blast_n` at 0.
- R8: A strobe with `lb_wr` at 0 (read) or `lb_mem` at 0 (I/O) stores nothing and does not change `lb_boff_n` or `wq_req`.
- R9: With `cfg_buf_en` at 0, the store holds one entry. A second word is backed off until the held word is taken.
- R10: A change of `cfg_buf_en` takes effect only on a clock at which both stores are empty and no word is being accepted. Until then the previous capacity applies.
- R11: `lb_boff_n` is 1 outside data phases, even when the store is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_buf_en | input | 1 | Control bit 0: 1 selects the four-entry queue, 0 the single holding register |
| lb_ads_n | input | 1 | Local address strobe, active low |
| lb_wr | input | 1 | Local write (1) or read (0) |
| lb_mem | input | 1 | Local memory (1) or I/O (0) select |
| lb_blast_n | input | 1 | Local burst-last, active low |
| lb_data | input | 32 | Local write data |
| lb_be_n | input | 4 | Local byte enables, active low |
| lb_boff_n | output | 1 | Back-off to the local writer, active low |
| wq_req | output | 1 | Request toward the master side: data waiting |
| wq_data | output | 32 | Head entry data |
| wq_be_n | output | 4 | Head entry byte enables, active low |
| wq_take | input | 1 | Drain side removes the head entry on this clock |

## Verification
`lb_boff_n` is decided within the same clock from the stored state and `wq_take`. An accepted word shows up on `wq_req` and the head outputs one clock edge after its data phase. A take also shifts the head one edge later. The bench drives all inputs at the falling edge and compares every output 1 ns later against a behavioural queue model. The model advances its state at each clock, so each expected value is due in exactly the cycle it is checked.

// File: rtl/pwbuf_pkg.sv
`timescale 1ns/1ps
package pwbuf_pkg;
    localparam int unsigned PW_DW  = 32;
    localparam int unsigned PW_BEW = PW_DW / 8;

    typedef struct packed {
        logic [PW_BEW-1:0] be_n;
        logic [PW_DW-1:0]  data;
    } pw_entry_t;
endpackage

// File: rtl/pwbuf_fifo.sv
`timescale 1ns/1ps
module pwbuf_fifo
    import pwbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  pw_entry_t        din,
    output pw_entry_t        dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        pw_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && (!full || pop);
    assign pop_ok  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp           = ptr_next(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = ptr_next(st_q.rp);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/pwbuf_hold.sv
`timescale 1ns/1ps
module pwbuf_hold
    import pwbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      take,
    input  pw_entry_t din,
    output pw_entry_t dout,
    output logic      full
);
    typedef struct packed {
        logic      full;
        pw_entry_t ent;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        if (load) begin
            st_d.full = 1'b1;
            st_d.ent  = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.ent;
    assign full = st_q.full;
endmodule

// File: rtl/pwbuf_lbcyc.sv
`timescale 1ns/1ps
module pwbuf_lbcyc (
    input  logic clk,
    input  logic rst,
    input  logic ads_n,
    input  logic wr,
    input  logic mem,
    input  logic blast_n,
    input  logic accept,
    output logic in_data
);
    typedef struct packed {
        logic active;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            st_d.active = !ads_n && wr && mem;
        end else if (accept && !blast_n) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign in_data = st_q.active;
endmodule

// File: rtl/pwbuf_top.sv
`timescale 1ns/1ps
module pwbuf_top
    import pwbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_buf_en,
    input  logic              lb_ads_n,
    input  logic              lb_wr,
    input  logic              lb_mem,
    input  logic              lb_blast_n,
    input  logic [PW_DW-1:0]  lb_data,
    input  logic [PW_BEW-1:0] lb_be_n,
    output logic              lb_boff_n,
    output logic              wq_req,
    output logic [PW_DW-1:0]  wq_data,
    output logic [PW_BEW-1:0] wq_be_n,
    input  logic              wq_take
);
    typedef struct packed {
        logic buf_mode;
    } top_st_t;

    top_st_t st_d, st_q;

    pw_entry_t      in_ent, fifo_out, hold_out, head;
    logic [CW-1:0]  fifo_cnt;
    logic           fifo_full, fifo_empty, hold_full;
    logic           in_data, space_full, pop, backoff, accept;
    logic           mode_now;

    assign mode_now   = st_q.buf_mode;
    assign in_ent     = '{be_n: lb_be_n, data: lb_data};
    assign space_full = mode_now ? fifo_full : hold_full;
    assign wq_req     = mode_now ? !fifo_empty : hold_full;
    assign pop        = wq_take && wq_req;
    assign backoff    = in_data && space_full && !pop;
    assign accept     = in_data && !backoff;
    assign lb_boff_n  = !backoff;
    assign head       = mode_now ? fifo_out : hold_out;
    assign wq_data    = head.data;
    assign wq_be_n    = head.be_n;

    pwbuf_lbcyc u_cyc (
        .clk     (clk),
        .rst     (rst),
        .ads_n   (lb_ads_n),
        .wr      (lb_wr),
        .mem     (lb_mem),
        .blast_n (lb_blast_n),
        .accept  (accept),
        .in_data (in_data)
    );

    pwbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (accept && mode_now),
        .pop   (pop && mode_now),
        .din   (in_ent),
        .dout  (fifo_out),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwbuf_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (accept && !mode_now),
        .take (pop && !mode_now),
        .din  (in_ent),
        .dout (hold_out),
        .full (hold_full)
    );

    always_comb begin
        st_d = st_q;
        if (fifo_empty && !hold_full && !accept) begin
            st_d.buf_mode = cfg_buf_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{buf_mode: 1'b1};
        else     st_q <= st_d;
    end
endmodule

// File: rtl/pwbuf_chk.sv
`timescale 1ns/1ps
module pwbuf_chk #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          boff_n,
    input logic          req,
    input logic          take,
    input logic [CW-1:0] fifo_cnt,
    input logic          hold_full,
    input logic          mode,
    input logic          in_data
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!req && boff_n));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

    assert_full_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CW'(DEPTH) && !take) |=> (fifo_cnt == CW'(DEPTH)));

    assert_req_persists_R6: assert property (@(posedge clk) disable iff (rst)
        (req && !take) |=> req);

    assert_fifo_idle_passthru_R9: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (fifo_cnt == '0));

    assert_mode_change_empty_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> ($past(fifo_cnt) == '0 && !$past(hold_full)));

    assert_boff_in_data_R11: assert property (@(posedge clk) disable iff (rst)
        !in_data |-> boff_n);
endmodule

bind pwbuf_top pwbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .boff_n    (lb_boff_n),
    .req       (wq_req),
    .take      (wq_take),
    .fifo_cnt  (fifo_cnt),
    .hold_full (hold_full),
    .mode      (mode_now),
    .in_data   (in_data)
);

// File: tb/pwbuf_top_bench.sv
`timescale 1ns/1ps
module pwbuf_top_bench;
    localparam int DEPTH  = 4;
    localparam int PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_buf_en = 1'b1;
    logic        lb_ads_n = 1'b1, lb_wr = 1'b0, lb_mem = 1'b0, lb_blast_n = 1'b1;
    logic [31:0] lb_data = '0;
    logic [3:0]  lb_be_n = 4'hF;
    logic        lb_boff_n, wq_req;
    logic [31:0] wq_data;
    logic [3:0]  wq_be_n;
    logic        wq_take = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [35:0] mq[$];
    bit    m_burst = 0;
    bit    m_mode  = 1;
    bit    last_acc = 0;
    string tag_boff = "R1", tag_req = "R1", tag_data = "R2";

    always #(PERIOD/2) clk = ~clk;

    pwbuf_top #(.DEPTH(DEPTH)) u_pwbuf_top (
        .clk(clk), .rst(rst), .cfg_buf_en(cfg_buf_en),
        .lb_ads_n(lb_ads_n), .lb_wr(lb_wr), .lb_mem(lb_mem), .lb_blast_n(lb_blast_n),
        .lb_data(lb_data), .lb_be_n(lb_be_n), .lb_boff_n(lb_boff_n),
        .wq_req(wq_req), .wq_data(wq_data), .wq_be_n(wq_be_n), .wq_take(wq_take)
    );

    task automatic check_val(input logic [35:0] got, input logic [35:0] exp,
                             input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic tick();
        int cap;
        bit pop, exp_boff, acc, nb;
        #1;
        if (!rst) begin
            cap      = m_mode ? DEPTH : 1;
            pop      = wq_take && (mq.size() != 0);
            exp_boff = m_burst && (mq.size() == cap) && !pop;
            check_val(36'(lb_boff_n), 36'(!exp_boff), tag_boff, "lb_boff_n");
            check_val(36'(wq_req), 36'(mq.size() != 0), tag_req, "wq_req");
            if (mq.size() != 0) check_val({wq_be_n, wq_data}, mq[0], tag_data, "head");
            acc      = m_burst && !exp_boff;
            last_acc = acc;
            if (!m_burst) nb = !lb_ads_n && lb_wr && lb_mem;
            else          nb = !(acc && !lb_blast_n);
            if (mq.size() == 0 && !acc) m_mode = cfg_buf_en;
            if (pop) void'(mq.pop_front());
            if (acc) mq.push_back({lb_be_n, lb_data});
            m_burst = nb;
        end else begin
            mq.delete();
            m_burst  = 0;
            m_mode   = 1;
            last_acc = 0;
        end
        @(negedge clk);
    endtask

    // tk: 0 never take, 1 always, 2 every third cycle, 3 from cycle 6 on
    task automatic wr_burst(input int n, input logic [31:0] base, input int tk,
                            input logic wr_sel, input logic mem_sel);
        int i = 0;
        int cyc = 0;
        lb_ads_n = 1'b0; lb_wr = wr_sel; lb_mem = mem_sel; lb_blast_n = 1'b1;
        wq_take = (tk == 1);
        tick();
        lb_ads_n = 1'b1;
        if (!(wr_sel && mem_sel)) begin
            lb_data = base; lb_be_n = 4'h0; lb_blast_n = 1'b0; wq_take = 1'b0;
            tick();
            lb_blast_n = 1'b1;
            return;
        end
        while (i < n) begin
            lb_data    = base + 32'(i);
            lb_be_n    = 4'(i) ^ 4'hA;
            lb_blast_n = (i == n - 1) ? 1'b0 : 1'b1;
            case (tk)
                1:       wq_take = 1'b1;
                2:       wq_take = (cyc % 3 == 2);
                3:       wq_take = (cyc >= 6);
                default: wq_take = 1'b0;
            endcase
            tick();
            if (last_acc) i++;
            cyc++;
        end
        lb_blast_n = 1'b1; wq_take = 1'b0; lb_wr = 1'b0; lb_mem = 1'b0;
    endtask

    task automatic drain();
        wq_take = 1'b1;
        while (mq.size() != 0) tick();
        wq_take = 1'b0;
        tick();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL R7 watchdog got running exp finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        idle(3);
        // R1: outputs during reset
        check_val(36'(lb_boff_n), 36'd1, "R1", "lb_boff_n in reset");
        check_val(36'(wq_req), 36'd0, "R1", "wq_req in reset");
        rst = 1'b0;
        tag_boff = "R1"; tag_req = "R1";
        idle(2);

        // R7 / R6: single write opens on strobe, closes on burst-last
        tag_boff = "R7"; tag_req = "R6"; tag_data = "R2";
        wr_burst(1, 32'h1000_0000, 0, 1'b1, 1'b1);
        idle(2);
        drain();

        // R3: four-word burst at full rate, no back-off
        tag_boff = "R3"; tag_req = "R6";
        wr_burst(4, 32'h2000_0000, 0, 1'b1, 1'b1);
        drain();

        // R4 / R5: six words into four entries, late drain
        tag_boff = "R4 R5"; tag_req = "R6";
        wr_burst(6, 32'h3000_0000, 3, 1'b1, 1'b1);

        // R11: store full outside a data phase
        tag_boff = "R11";
        idle(3);

        // R8: read and I/O strobes store nothing
        tag_boff = "R8"; tag_req = "R8";
        wr_burst(1, 32'h4000_0000, 0, 1'b0, 1'b1);
        tag_data = "R2";
        drain();
        wr_burst(1, 32'h4100_0000, 0, 1'b1, 1'b0);
        idle(2);

        // R10: clearing the enable with data waiting keeps capacity four
        tag_boff = "R10"; tag_req = "R6";
        cfg_buf_en = 1'b1;
        wr_burst(2, 32'h5000_0000, 0, 1'b1, 1'b1);
        cfg_buf_en = 1'b0;
        wr_burst(2, 32'h5100_0000, 0, 1'b1, 1'b1);
        idle(1);
        drain();

        // R9: pass-through holds one word
        tag_boff = "R9";
        wr_burst(3, 32'h6000_0000, 2, 1'b1, 1'b1);
        drain();
        tag_boff = "R5";
        wr_burst(4, 32'h6100_0000, 1, 1'b1, 1'b1);
        drain();

        // back to the queue
        cfg_buf_en = 1'b1;
        idle(2);
        tag_boff = "R3";
        wr_burst(3, 32'h7000_0000, 2, 1'b1, 1'b1);
        drain();
        idle(2);
        finish_run();
    end
endmodule